// File: doc/BRIEF.md
# USB Bus Suspend and Resume Detector

This block sits behind a USB packet decoder. It watches two inputs: a bus activity indication and a start-of-frame pulse. From them it tracks how long the bus has been idle. A prescaler derived from the system clock frequency produces a one-millisecond tick, and an idle counter counts those ticks.

When the bus stays quiet for the configured number of milliseconds, the block enters the suspended state and raises a suspend event. Activity seen while suspended raises an end-suspend event and asserts a wake output, which brings the system out of its halt state. Wake stays high until the first start-of-frame after the resume. That start-of-frame, like every other one, raises the start-of-frame event, so software sees it as the marker that the resume has finished.

A bus reset indication raises its own event. The four event flags are sticky and are cleared by software, one at a time or together. Each flag has its own mask bit, and the masked flags share one interrupt line.

Top module: `usb_susp_det`

## Requirements
- R1: After reset, `flags`, `mask`, `irq`, `wake` and `suspended` are all zero.
- R2: The suspend flag (`flags` bit 2) is set, and `suspended` goes high, once `SUSP_MS*(CLK_HZ/1000)` consecutive clock cycles have passed without `bus_activity` after the last cycle in which it was high. One cycle earlier, both are still low.
- R3: Every cycle with `bus_activity` high restarts the idle count from zero, and the idle count saturates at `SUSP_MS`.
- R4: A suspend event is raised only once per idle period. After software clears the suspend flag, it stays clear and `suspended` stays high for as long as the bus remains idle.
- R5: `bus_activity` high while `suspended` is high sets the end-suspend flag (`flags` bit 3), drives `wake` high and `suspended` low, all visible in the following cycle.
- R6: Every `sof_pulse` sets the start-of-frame flag (`flags` bit 0) in the following cycle.
- R7: The first `sof_pulse` after an end-suspend event drops `wake` in the following cycle; that same start-of-frame sets the start-of-frame flag, marking the end of the resume.
- R8: A `bus_reset` pulse sets the reset flag (`flags` bit 1) in the following cycle.
- R9: A flag stays set until a cycle with `flag_clr_we` high and a 0 in that bit of `flag_clr_data`. A 1 in a bit of `flag_clr_data` leaves that flag unchanged. An event arriving in the same cycle as its clear leaves the flag set.
- R10: `mask` loads `mask_data` on a cycle with `mask_we` high. `irq` is high exactly when some bit is set in both `flags` and `mask`.
- R11: `bus_activity` while not suspended does not set the end-suspend flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_activity | input | 1 | Decoder reports bus activity this cycle |
| sof_pulse | input | 1 | One-cycle pulse per received start-of-frame |
| bus_reset | input | 1 | One-cycle pulse when a bus reset is detected |
| flag_clr_we | input | 1 | Write strobe for flag clearing |
| flag_clr_data | input | 4 | Per-flag clear value; a 0 clears that flag |
| mask_we | input | 1 | Write strobe for the mask |
| mask_data | input | 4 | New mask value |
| flags | output | 4 | Event flags: bit0 SOF, bit1 reset, bit2 suspend, bit3 end-suspend |
| mask | output | 4 | Current mask, with the same bit order as `flags` |
| irq | output | 1 | OR of the masked flags |
| wake | output | 1 | Held high from end-suspend until the resume completes |
| suspended | output | 1 | Bus is in the suspended state |

## Verification
A software clear can land in the same cycle as a new event on the same flag. The bench provokes this by pulsing start-of-frame in the very cycle that a clear write of all zeros is presented. It judges the outcome by checking that the start-of-frame flag remains set while the reset flag, which had no new event, is cleared. It also sweeps the idle gap across the suspend threshold cycle by cycle, to confirm that the suspend event and a returning activity indication never produce a spurious end-suspend.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
    localparam int EV_N     = 4;
    localparam int EV_SOF   = 0;
    localparam int EV_RST   = 1;
    localparam int EV_SUSP  = 2;
    localparam int EV_ESUSP = 3;

    typedef logic [EV_N-1:0] ev_vec_t;
endpackage

// File: rtl/usb_ms_prescaler.sv
module usb_ms_prescaler #(
    parameter int CLK_HZ = 48_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int W   = (CYC < 2) ? 1 : $clog2(CYC);
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: the divider never runs past one millisecond of cycles
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
endmodule

// File: rtl/usb_idle_tracker.sv
module usb_idle_tracker #(
    parameter int SUSP_MS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic activity,
    input  logic sof,
    output logic susp_evt,
    output logic esusp_evt,
    output logic wake,
    output logic suspended
);
    localparam int CW = $clog2(SUSP_MS + 1);
    localparam logic [CW-1:0] SAT    = CW'(SUSP_MS);
    localparam logic [CW-1:0] BEFORE = CW'(SUSP_MS - 1);

    typedef struct packed {
        logic [CW-1:0] idle_cnt;
        logic          susp;
        logic          wake;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        susp_evt  = 1'b0;
        esusp_evt = 1'b0;
        if (sof && st_q.wake) begin
            st_d.wake = 1'b0;
        end
        if (activity) begin
            st_d.idle_cnt = '0;
            if (st_q.susp) begin
                esusp_evt = 1'b1;
                st_d.susp = 1'b0;
                st_d.wake = 1'b1;
            end
        end else if (tick && st_q.idle_cnt != SAT) begin
            st_d.idle_cnt = st_q.idle_cnt + 1'b1;
            if (st_q.idle_cnt == BEFORE && !st_q.susp) begin
                susp_evt  = 1'b1;
                st_d.susp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake      = st_q.wake;
    assign suspended = st_q.susp;

    // R3: the idle count saturates at the threshold
    assert_idle_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idle_cnt <= SAT);
    // R2: entering suspend requires an idle cycle
    assert_susp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.susp) |-> !$past(activity));
    // R4: suspend is held while the bus stays idle
    assert_susp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.susp && !activity |=> st_q.susp);
    // R5: wake rises only from activity during suspend
    assert_wake_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wake) |-> $past(activity) && $past(st_q.susp));
    // R7: wake falls only on a start-of-frame
    assert_wake_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.wake) |-> $past(sof));
endmodule

// File: rtl/usb_event_regs.sv
module usb_event_regs
    import usb_susp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ev_vec_t set_ev,
    input  logic    clr_we,
    input  ev_vec_t clr_data,
    input  logic    mask_we,
    input  ev_vec_t mask_data,
    output ev_vec_t flags,
    output ev_vec_t mask,
    output logic    irq
);
    typedef struct packed {
        ev_vec_t flags;
        ev_vec_t mask;
    } st_t;

    st_t     st_d, st_q;
    ev_vec_t flag_nxt;

    for (genvar i = 0; i < EV_N; i++) begin : g_flag
        logic kill;
        assign kill        = clr_we && !clr_data[i];
        assign flag_nxt[i] = set_ev[i] || (st_q.flags[i] && !kill);

        // R9: a flag holds unless its clear bit is written as 0
        assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.flags[i] && !kill |=> st_q.flags[i]);
        // R6: an event sets its flag in the next cycle
        assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> st_q.flags[i]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = flag_nxt;
        if (mask_we) st_d.mask = mask_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
    assign mask  = st_q.mask;
    assign irq   = |(st_q.flags & st_q.mask);

    // R10: a fully masked block never interrupts
    assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mask == '0 |-> !irq);
endmodule

// File: rtl/usb_susp_det.sv
module usb_susp_det
    import usb_susp_pkg::*;
#(
    parameter int CLK_HZ  = 48_000_000,
    parameter int SUSP_MS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_activity,
    input  logic            sof_pulse,
    input  logic            bus_reset,
    input  logic            flag_clr_we,
    input  logic [EV_N-1:0] flag_clr_data,
    input  logic            mask_we,
    input  logic [EV_N-1:0] mask_data,
    output logic [EV_N-1:0] flags,
    output logic [EV_N-1:0] mask,
    output logic            irq,
    output logic            wake,
    output logic            suspended
);
    logic    ms_tick;
    logic    susp_evt;
    logic    esusp_evt;
    ev_vec_t set_ev;

    usb_ms_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (bus_activity),
        .tick    (ms_tick)
    );

    usb_idle_tracker #(.SUSP_MS(SUSP_MS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (ms_tick),
        .activity  (bus_activity),
        .sof       (sof_pulse),
        .susp_evt  (susp_evt),
        .esusp_evt (esusp_evt),
        .wake      (wake),
        .suspended (suspended)
    );

    always_comb begin
        set_ev           = '0;
        set_ev[EV_SOF]   = sof_pulse;
        set_ev[EV_RST]   = bus_reset;
        set_ev[EV_SUSP]  = susp_evt;
        set_ev[EV_ESUSP] = esusp_evt;
    end

    usb_event_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (set_ev),
        .clr_we    (flag_clr_we),
        .clr_data  (flag_clr_data),
        .mask_we   (mask_we),
        .mask_data (mask_data),
        .flags     (flags),
        .mask      (mask),
        .irq       (irq)
    );

    // R11: end-suspend only comes out of the suspended state
    assert_esusp_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[EV_ESUSP]) |-> $past(suspended));
endmodule

// File: tb/usb_susp_det_test.sv
module usb_susp_det_test;
    localparam int CLK_T   = 10;
    localparam int HZ      = 8000;
    localparam int MS      = 3;
    localparam int THRESH  = MS * (HZ / 1000);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       act = 1'b0, sof = 1'b0, brst = 1'b0;
    logic       cwe = 1'b0, mwe = 1'b0;
    logic [3:0] cdat = 4'hF, mdat = 4'h0;
    logic [3:0] flags, mask;
    logic       irq, wake, suspended;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_T / 2) clk = ~clk;

    usb_susp_det #(.CLK_HZ(HZ), .SUSP_MS(MS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_activity(act), .sof_pulse(sof),
        .bus_reset(brst), .flag_clr_we(cwe), .flag_clr_data(cdat),
        .mask_we(mwe), .mask_data(mdat), .flags(flags), .mask(mask),
        .irq(irq), .wake(wake), .suspended(suspended)
    );

    task automatic check(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_act();
        act = 1'b1; cyc(1); act = 1'b0;
    endtask

    task automatic pulse_sof();
        sof = 1'b1; cyc(1); sof = 1'b0;
    endtask

    task automatic clear_all();
        cwe = 1'b1; cdat = 4'h0; cyc(1); cwe = 1'b0; cdat = 4'hF;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check("R1 flags", int'(flags), 0);
        check("R1 mask", int'(mask), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 wake", int'(wake), 0);
        check("R1 suspended", int'(suspended), 0);

        // R2 / R5 / R11 / R6 / R7: sweep idle gap across the threshold
        for (int g = 0; g <= THRESH + 6; g++) begin
            pulse_act();
            cyc(g);
            check($sformatf("R2 susp flag gap %0d", g), int'(flags[2]), int'(g >= THRESH));
            check($sformatf("R2 suspended gap %0d", g), int'(suspended), int'(g >= THRESH));
            pulse_act();
            check($sformatf("R5/R11 esusp gap %0d", g), int'(flags[3]), int'(g >= THRESH));
            check($sformatf("R5 wake gap %0d", g), int'(wake), int'(g >= THRESH));
            check($sformatf("R5 not suspended gap %0d", g), int'(suspended), 0);
            pulse_sof();
            check($sformatf("R7 wake dropped gap %0d", g), int'(wake), 0);
            check($sformatf("R6 sof flag gap %0d", g), int'(flags[0]), 1);
            clear_all();
            check($sformatf("R9 cleared gap %0d", g), int'(flags), 0);
        end

        // R3: activity restarts the idle count
        pulse_act();
        cyc(THRESH - 4);
        pulse_act();
        cyc(THRESH - 1);
        check("R3 restart, one cycle short", int'(flags[2]), 0);
        cyc(1);
        check("R3 restart, at threshold", int'(flags[2]), 1);

        // R4: no second suspend event in the same idle period
        clear_all();
        cyc(5 * THRESH);
        check("R4 no repeat suspend flag", int'(flags[2]), 0);
        check("R4 still suspended", int'(suspended), 1);

        // R5 then R7 with wake held until start-of-frame
        pulse_act();
        cyc(2);
        check("R5 wake held", int'(wake), 1);
        check("R5 esusp set", int'(flags[3]), 1);
        pulse_sof();
        check("R7 resume done wake", int'(wake), 0);
        check("R7 resume done sof flag", int'(flags[0]), 1);

        // keep bus busy for the register sweeps
        act = 1'b1;
        clear_all();
        check("R9 clear under activity", int'(flags), 0);

        // R8: bus reset flag
        brst = 1'b1; cyc(1); brst = 1'b0;
        check("R8 reset flag", int'(flags), 2);

        // R9: event and clear in the same cycle
        sof = 1'b1; cwe = 1'b1; cdat = 4'h0;
        cyc(1);
        sof = 1'b0; cwe = 1'b0; cdat = 4'hF;
        check("R9 set wins over clear", int'(flags), 1);
        clear_all();

        // R9: clear pattern sweep
        for (int w = 0; w < 16; w++) begin
            sof = 1'b1; brst = 1'b1; cyc(1); sof = 1'b0; brst = 1'b0;
            cwe = 1'b1; cdat = 4'(w); cyc(1); cwe = 1'b0; cdat = 4'hF;
            check($sformatf("R9 clear pattern %0d", w), int'(flags), 3 & w);
            clear_all();
        end

        // R10: mask and irq sweep
        for (int m = 0; m < 16; m++) begin
            for (int f = 0; f < 4; f++) begin
                clear_all();
                sof = f[0]; brst = f[1]; cyc(1); sof = 1'b0; brst = 1'b0;
                mwe = 1'b1; mdat = 4'(m); cyc(1); mwe = 1'b0;
                check($sformatf("R10 mask %0d", m), int'(mask), m);
                check($sformatf("R10 irq m%0d f%0d", m, f), int'(irq), int'((m & f) != 0));
            end
        end
        act = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_T * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule